// File: doc/BRIEF.md
# Unframed All-Ones Detector

This block watches a received serial bit stream that arrives with a per-bit valid strobe, together with an out-of-frame status input from a separate framer. It raises an alarm when the line appears to carry an unframed all-ones signal. An unframed all-ones signal is a stream that is almost free of zeros and on which the framer cannot find alignment. The stream is cut into back-to-back windows of 2047 valid bits. For each window the block counts the zeros and records two things: whether out-of-frame was high on every valid bit, and whether it was low on every valid bit.

At the end of each window a small judge grades it as declare-qualifying, clear-qualifying or neither. A two-state machine then counts consecutive windows of the grade that matters in its current state. The machine has two states. ST_CLEAR means no alarm. ST_SET means the alarm is raised. Four declare-qualifying windows in a row move ST_CLEAR to ST_SET (the DECLARE transition). Four clear-qualifying windows in a row move ST_SET to ST_CLEAR (the TERMINATE transition). Any other window keeps the state (HOLD) and zeroes the run count when it does not qualify. The alarm changes only at window boundaries, and each change is marked by a one-cycle pulse.

Top module: `ones_alarm_det`

## Requirements
- R1: After reset `alarm_o` is 0, `alarm_chg_o` is 0, the machine is in ST_CLEAR with an empty run count, and a new window begins with the next valid bit.
- R2: A window is exactly 2047 cycles with `bit_vld`=1. On cycles with `bit_vld`=0, `bit_in` and `oof_in` have no effect on any window's zero count or out-of-frame record.
- R3: A window is declare-qualifying when it holds at most five zeros (a zero is `bit_in`=0) and `oof_in` was 1 on every one of its valid bits.
- R4: In ST_CLEAR, the fourth declare-qualifying window in a row causes DECLARE: `alarm_o` becomes 1.
- R5: A window is clear-qualifying when it holds six or more zeros, or when `oof_in` was 0 on every one of its valid bits.
- R6: In ST_SET, the fourth clear-qualifying window in a row causes TERMINATE: `alarm_o` becomes 0.
- R7: A window that does not qualify for the current state's transition resets that state's run count to zero. A declare-qualifying window seen in ST_SET is one such window.
- R8: `alarm_o` changes only in the second cycle after the clock edge that takes a window's last valid bit. `alarm_chg_o` is 1 for exactly that one cycle and is 0 at all other times.
- R9: The per-window zero count saturates at seven. A window with any number of zeros above five, including eight or more, never counts as declare-qualifying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Marks `bit_in` and `oof_in` as a valid bit this cycle |
| bit_in | input | 1 | Received data bit |
| oof_in | input | 1 | Out-of-frame status from the framer, sampled with each valid bit |
| alarm_o | output | 1 | Unframed all-ones condition, 1 when declared |
| alarm_chg_o | output | 1 | One-cycle pulse when `alarm_o` changes |

## Verification
On every cycle, the assertions check the following. Idle cycles leave the window position and zero count unchanged. A window-end strobe only follows a valid bit. The state only moves one cycle after a window end. Every change pulse lines up with an actual alarm change. Each alarm rise or fall is backed by a window of the matching grade. The two grades never hold together. Only the bench scenarios can show the count of four in a row and the run reset by a broken sequence. They also cover saturation with eight to twelve zeros, garbage on idle cycles being ignored, and a window with mixed out-of-frame status qualifying for neither direction. All of these are compared against a window-level reference model in the bench.

// File: rtl/uad_pkg.sv
package uad_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } uad_state_e;

    typedef struct packed {
        logic oof_all_hi;
        logic oof_all_lo;
    } uad_oof_rec_t;

endpackage

// File: rtl/uad_window.sv
module uad_window #(
    parameter int WIN_BITS = 2047,
    parameter int ZSAT     = 7,
    parameter int ZW       = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_vld,
    input  logic                  bit_in,
    input  logic                  oof_in,
    output logic                  win_done,
    output logic [ZW-1:0]         win_zeros,
    output uad_pkg::uad_oof_rec_t win_oof
);
    import uad_pkg::*;

    localparam int POS_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;

    logic [POS_W-1:0] pos_q;
    logic [ZW-1:0]    zcnt_q;
    logic [ZW-1:0]    zcnt_nx;
    uad_oof_rec_t     rec_q;
    uad_oof_rec_t     rec_nx;
    logic             last_bit;

    assign last_bit = (pos_q == POS_W'(WIN_BITS - 1));

    always_comb begin
        zcnt_nx = zcnt_q;
        if (!bit_in && (zcnt_q != ZW'(ZSAT))) begin
            zcnt_nx = zcnt_q + ZW'(1);
        end
        rec_nx.oof_all_hi = rec_q.oof_all_hi & oof_in;
        rec_nx.oof_all_lo = rec_q.oof_all_lo & ~oof_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= '0;
            zcnt_q    <= '0;
            rec_q     <= '{oof_all_hi: 1'b1, oof_all_lo: 1'b1};
            win_done  <= 1'b0;
            win_zeros <= '0;
            win_oof   <= '{oof_all_hi: 1'b0, oof_all_lo: 1'b0};
        end else begin
            win_done <= 1'b0;
            if (bit_vld) begin
                if (last_bit) begin
                    pos_q     <= '0;
                    zcnt_q    <= '0;
                    rec_q     <= '{oof_all_hi: 1'b1, oof_all_lo: 1'b1};
                    win_done  <= 1'b1;
                    win_zeros <= zcnt_nx;
                    win_oof   <= rec_nx;
                end else begin
                    pos_q  <= pos_q + POS_W'(1);
                    zcnt_q <= zcnt_nx;
                    rec_q  <= rec_nx;
                end
            end
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(pos_q) && $stable(zcnt_q)));

    // R2
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(bit_vld));

    // R9
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zcnt_q == ZW'(ZSAT)) && bit_vld && !last_bit |=> (zcnt_q == ZW'(ZSAT)));

endmodule

// File: rtl/uad_judge.sv
module uad_judge #(
    parameter int ZERO_LIMIT = 5,
    parameter int ZW         = 3
) (
    input  logic [ZW-1:0]         win_zeros,
    input  uad_pkg::uad_oof_rec_t win_oof,
    output logic                  set_ok,
    output logic                  clr_ok
);
    import uad_pkg::*;

    logic sparse;

    always_comb begin
        sparse = (win_zeros <= ZW'(ZERO_LIMIT));
        set_ok = sparse && win_oof.oof_all_hi;
        clr_ok = !sparse || win_oof.oof_all_lo;
    end

endmodule

// File: rtl/uad_fsm.sv
module uad_fsm #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_done,
    input  logic set_ok,
    input  logic clr_ok,
    output logic alarm_o,
    output logic alarm_chg_o
);
    import uad_pkg::*;

    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

    uad_state_e       state_q;
    uad_state_e       state_nx;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             run_full;
    logic             qual;

    assign run_full = (run_q == RUN_W'(RUN_LEN - 1));

    always_comb begin
        state_nx = state_q;
        run_nx   = run_q;
        qual     = 1'b0;
        unique case (state_q)
            ST_CLEAR: qual = set_ok;
            ST_SET:   qual = clr_ok;
        endcase
        if (win_done) begin
            if (!qual) begin
                run_nx = '0;
            end else if (run_full) begin
                run_nx = '0;
                unique case (state_q)
                    ST_CLEAR: state_nx = ST_SET;
                    ST_SET:   state_nx = ST_CLEAR;
                endcase
            end else begin
                run_nx = run_q + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            run_q   <= '0;
        end else begin
            state_q <= state_nx;
            run_q   <= run_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_chg_o <= 1'b0;
        end else begin
            alarm_chg_o <= (state_nx != state_q);
        end
    end

    assign alarm_o = (state_q == ST_SET);

    // R8
    move_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> $past(win_done));

    // R8
    pulse_matches_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_chg_o |-> (alarm_o != $past(alarm_o)));

    // R4
    declare_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(set_ok));

    // R6
    terminate_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_o) |-> $past(clr_ok));

    // R5
    grades_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> !(set_ok && clr_ok));

endmodule

// File: rtl/ones_alarm_det.sv
module ones_alarm_det #(
    parameter int WIN_BITS   = 2047,
    parameter int ZERO_LIMIT = 5,
    parameter int RUN_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic oof_in,
    output logic alarm_o,
    output logic alarm_chg_o
);
    import uad_pkg::*;

    localparam int ZSAT = ZERO_LIMIT + 2;
    localparam int ZW   = $clog2(ZSAT + 1);

    logic          win_done;
    logic [ZW-1:0] win_zeros;
    uad_oof_rec_t  win_oof;
    logic          set_ok;
    logic          clr_ok;

    uad_window #(
        .WIN_BITS (WIN_BITS),
        .ZSAT     (ZSAT),
        .ZW       (ZW)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .oof_in    (oof_in),
        .win_done  (win_done),
        .win_zeros (win_zeros),
        .win_oof   (win_oof)
    );

    uad_judge #(
        .ZERO_LIMIT (ZERO_LIMIT),
        .ZW         (ZW)
    ) u_judge (
        .win_zeros (win_zeros),
        .win_oof   (win_oof),
        .set_ok    (set_ok),
        .clr_ok    (clr_ok)
    );

    uad_fsm #(
        .RUN_LEN (RUN_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_done    (win_done),
        .set_ok      (set_ok),
        .clr_ok      (clr_ok),
        .alarm_o     (alarm_o),
        .alarm_chg_o (alarm_chg_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!alarm_o && !alarm_chg_o));

endmodule

// File: tb/tb_ones_alarm_det.sv
module tb_ones_alarm_det;

    localparam int WIN = 2047;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b1;
    logic oof_in = 1'b0;
    logic alarm_o;
    logic alarm_chg_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit m_alarm = 1'b0;
    int m_run = 0;
    bit m_chg = 1'b0;

    ones_alarm_det dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_vld),
        .bit_in      (bit_in),
        .oof_in      (oof_in),
        .alarm_o     (alarm_o),
        .alarm_chg_o (alarm_chg_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // mode 0: oof high on all bits, 1: low on all bits, 2: mixed
    function automatic bit qual_declare(input int nz, input int mode);
        return (nz <= 5) && (mode == 0);
    endfunction

    function automatic bit qual_terminate(input int nz, input int mode);
        return (nz >= 6) || (mode == 1);
    endfunction

    function automatic void model_window(input int nz, input int mode);
        bit q;
        m_chg = 1'b0;
        q = m_alarm ? qual_terminate(nz, mode) : qual_declare(nz, mode);
        if (!q) begin
            m_run = 0;
        end else begin
            m_run++;
            if (m_run == 4) begin
                m_run = 0;
                m_alarm = !m_alarm;
                m_chg = 1'b1;
            end
        end
    endfunction

    task automatic send_window(input int nz, input int mode, input string tag);
        int off = $urandom_range(149);
        int sw = $urandom_range(WIN - 2, 1);
        int sent = 0;
        for (int i = 0; i < WIN; i++) begin
            while ($urandom_range(15) == 0) begin
                @(negedge clk);
                bit_vld = 1'b0;
                bit_in = 1'($urandom_range(1));
                oof_in = 1'($urandom_range(1));
            end
            @(negedge clk);
            if (i == 1000) begin
                check(tag, "R8 no pulse mid-window", int'(alarm_chg_o), 0);
                check(tag, "R8 alarm steady mid-window", int'(alarm_o), int'(m_alarm));
            end
            bit_vld = 1'b1;
            if ((sent < nz) && (i % 150 == off)) begin
                bit_in = 1'b0;
                sent++;
            end else begin
                bit_in = 1'b1;
            end
            case (mode)
                0: oof_in = 1'b1;
                1: oof_in = 1'b0;
                default: oof_in = (i < sw);
            endcase
        end
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in = 1'($urandom_range(1));
        oof_in = 1'($urandom_range(1));
        model_window(nz, mode);
        @(negedge clk);
        check(tag, "alarm after window", int'(alarm_o), int'(m_alarm));
        check(tag, "R8 change pulse", int'(alarm_chg_o), int'(m_chg));
        @(negedge clk);
        check(tag, "R8 pulse one cycle", int'(alarm_chg_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 195000) begin
                errors++;
                checks++;
                $display("FAIL watchdog R1 actual=%0d expected=done", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd5113));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "alarm after reset", int'(alarm_o), 0);
        check("R1", "pulse after reset", int'(alarm_chg_o), 0);

        // R3 R4 R7 R9: run broken by mixed oof, then by 8 zeros
        send_window(0, 0, "R3 R4");
        send_window(5, 0, "R3 R4");
        send_window(2, 0, "R3 R4");
        send_window(3, 2, "R7 mixed oof");
        send_window(5, 0, "R7");
        send_window(1, 0, "R7");
        send_window(4, 0, "R7");
        send_window(8, 0, "R9 eight zeros");
        send_window(0, 0, "R7");
        send_window(0, 0, "R7");
        send_window(5, 0, "R2 R4");
        send_window(3, 0, "R4 declare");
        // R5 R6 by oof low on every bit
        send_window(0, 1, "R5 R6");
        send_window(0, 1, "R5 R6");
        send_window(2, 0, "R7 in set");
        send_window(0, 1, "R5 R6");
        send_window(1, 1, "R5 R6");
        send_window(3, 1, "R5 R6");
        send_window(0, 1, "R6 terminate");
        // redeclare, then terminate by zero density
        for (int k = 0; k < 4; k++) send_window(k, 0, "R4");
        send_window(6, 0, "R5 six zeros");
        send_window(12, 0, "R5 R9 twelve zeros");
        send_window(7, 2, "R5 mixed dense");
        send_window(6, 0, "R6 terminate");
        // random mix
        for (int k = 0; k < 18; k++) begin
            int r = $urandom_range(3);
            int nz = (r == 0) ? $urandom_range(5) :
                     (r == 1) ? $urandom_range(12, 6) :
                     (($urandom_range(1) == 0) ? 5 : 6);
            int md = ($urandom_range(4) == 0) ? 2 : (m_alarm ? $urandom_range(1) : 0);
            send_window(nz, md, "R3 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule